// File: doc/BRIEF.md
# Load Effective Address Generator

This unit forms the memory address for a 64-bit fixed-point load. Each cycle it may accept one load described by its displacement form, its base register number and contents, its index register contents, its immediate field, its update flag and its target register number. It adds a base to an offset modulo 2^64. The base is either the base register contents or zero. The offset is either a scaled, sign-extended immediate or the index register. The unit presents the sum one cycle later, together with a qualifying valid.

For loads that update their base register, the unit also produces a writeback request: an enable and the value to write, which is the computed address. Two encodings of an update load are rejected. One uses base register 0. The other names the same register as both base and target. For either, the unit raises a bad-form flag and withholds the writeback. The address is still reported. The unit reads no memory, formats no data, and does not check alignment.

Top module: `lea_gen`

## Requirements
- R1: While `rst` is high at a rising edge, all outputs (`out_valid`, `ea`, `wb_en`, `wb_val`, `bad_form`) become 0 at that edge.
- R2: `out_valid` at each rising edge takes the value `in_valid` had just before that edge. `wb_en` and `bad_form` are 0 whenever `out_valid` is 0. `ea` and `wb_val` describe the load that was accepted at that edge.
- R3: For a load without update (`upd`=0) whose `ra_num` is 0, the base is zero and `ra_val` has no effect. For any other `ra_num`, the base is `ra_val`.
- R4: For a load with update (`upd`=1), the base is always `ra_val`, including when `ra_num` is 0.
- R5: With `form`=0 (D), the offset is `imm[15:0]` sign-extended to 64 bits.
- R6: With `form`=1 (DS), the offset is `{imm[15:2],2'b00}` sign-extended to 64 bits. `imm[1:0]` has no effect.
- R7: With `form`=2 (DQ), the offset is `{imm[15:4],4'b0000}` sign-extended to 64 bits. `imm[3:0]` has no effect.
- R8: With `form`=3 (indexed), the offset is `rb_val` and `imm` has no effect.
- R9: `ea` is base plus offset modulo 2^64. The carry out is dropped.
- R10: For a legal update load, `wb_en`=1 and `wb_val` equals `ea`.
- R11: An update load with `ra_num`=0 or `ra_num`=`rt_num` sets `bad_form`=1 and `wb_en`=0.
- R12: A load without update gives `wb_en`=0 and `bad_form`=0 for any register numbers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A load is presented this cycle |
| form | input | 2 | Offset form: 0 D, 1 DS, 2 DQ, 3 indexed |
| upd | input | 1 | Load updates its base register |
| ra_num | input | 5 | Base register number |
| rt_num | input | 5 | Target register number |
| ra_val | input | 64 | Base register contents |
| rb_val | input | 64 | Index register contents |
| imm | input | 16 | Immediate displacement field |
| out_valid | output | 1 | Registered outputs are valid |
| ea | output | 64 | Effective address |
| wb_en | output | 1 | Write `wb_val` into the base register |
| wb_val | output | 64 | Value for the base register writeback |
| bad_form | output | 1 | Update load with an illegal register pairing |

## Verification
The bench walks every form with update on and off, and register numbers 0, 1, 5 and 31 for both the base and the target. This separates the zero-base substitution from the update exemption, and legal from illegal pairings. Each combination runs with several value sets. One has low immediate bits set, which exposes an unmasked DS or DQ field. One has a negative immediate, which tests the sign extension. Others wrap past 2^64, to show the carry is dropped, or use a large index, to show the indexed form ignores the immediate. Idle cycles check that `out_valid` drops and that the qualified flags drop with it.

// File: rtl/lea_gen.sv
module lea_gen #(
  parameter int XLEN = 64,
  parameter int RFW  = 5,
  parameter int IMMW = 16,
  parameter int DS_LOW = 2,
  parameter int DQ_LOW = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [1:0]      form,
  input  logic            upd,
  input  logic [RFW-1:0]  ra_num,
  input  logic [RFW-1:0]  rt_num,
  input  logic [XLEN-1:0] ra_val,
  input  logic [XLEN-1:0] rb_val,
  input  logic [IMMW-1:0] imm,
  output logic            out_valid,
  output logic [XLEN-1:0] ea,
  output logic            wb_en,
  output logic [XLEN-1:0] wb_val,
  output logic            bad_form
);
  localparam int EXTW = XLEN - IMMW;
  localparam logic [1:0] F_D = 2'd0, F_DS = 2'd1, F_DQ = 2'd2;

  logic [XLEN-1:0] base, offset, sum;
  logic            illegal;

  assign base = (!upd && ra_num == '0) ? '0 : ra_val;

  always_comb begin
    case (form)
      F_D:     offset = {{EXTW{imm[IMMW-1]}}, imm};
      F_DS:    offset = {{EXTW{imm[IMMW-1]}}, imm[IMMW-1:DS_LOW], {DS_LOW{1'b0}}};
      F_DQ:    offset = {{EXTW{imm[IMMW-1]}}, imm[IMMW-1:DQ_LOW], {DQ_LOW{1'b0}}};
      default: offset = rb_val;
    endcase
  end

  assign sum     = base + offset;
  assign illegal = upd && (ra_num == '0 || ra_num == rt_num);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      ea        <= '0;
      wb_en     <= 1'b0;
      wb_val    <= '0;
      bad_form  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      wb_en     <= in_valid && upd && !illegal;
      bad_form  <= in_valid && illegal;
      if (in_valid) begin
        ea     <= sum;
        wb_val <= sum;
      end
    end
  end

  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> (!wb_en && !bad_form));
  assert_zero_base_R3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !upd && ra_num == '0 && form == 2'd3) |=> (ea == $past(rb_val)));
  assert_wb_only_update_R10: assert property (@(posedge clk) disable iff (rst)
    wb_en |-> $past(upd));
  assert_bad_blocks_wb_R11: assert property (@(posedge clk) disable iff (rst)
    bad_form |-> !wb_en);
  assert_no_update_no_flags_R12: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !upd) |=> (!wb_en && !bad_form));
endmodule

// File: tb/lea_gen_tb.sv
module lea_gen_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [1:0]  form = '0;
  logic        upd = 1'b0;
  logic [4:0]  ra_num = '0, rt_num = '0;
  logic [63:0] ra_val = '0, rb_val = '0;
  logic [15:0] imm = '0;
  logic        out_valid, wb_en, bad_form;
  logic [63:0] ea, wb_val;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  lea_gen u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .form(form), .upd(upd),
    .ra_num(ra_num), .rt_num(rt_num), .ra_val(ra_val), .rb_val(rb_val),
    .imm(imm), .out_valid(out_valid), .ea(ea), .wb_en(wb_en),
    .wb_val(wb_val), .bad_form(bad_form)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] exp_ea(input logic [1:0] f, input logic u,
      input logic [4:0] ra, input logic [63:0] rav, input logic [63:0] rbv,
      input logic [15:0] im);
    logic [63:0] b, o;
    logic signed [63:0] s;
    b = (!u && ra == 0) ? 64'd0 : rav;
    s = 64'(signed'(im));
    case (f)
      2'd0: o = s;
      2'd1: o = s - 64'(im[1:0]);
      2'd2: o = s - 64'(im[3:0]);
      default: o = rbv;
    endcase
    return b + o;
  endfunction

  function automatic logic [4:0] regsel(input int i);
    case (i)
      0: return 5'd0;
      1: return 5'd1;
      2: return 5'd5;
      default: return 5'd31;
    endcase
  endfunction

  initial begin
    #2_000_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    in_valid = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R1 out_valid", 64'(out_valid), 0);
    chk("R1 ea", ea, 0);
    chk("R1 wb_en", 64'(wb_en), 0);
    chk("R1 wb_val", wb_val, 0);
    chk("R1 bad_form", 64'(bad_form), 0);
    rst = 1'b0;
    in_valid = 1'b0;
    for (int f = 0; f < 4; f++)
      for (int u = 0; u < 2; u++)
        for (int a = 0; a < 4; a++)
          for (int t = 0; t < 4; t++)
            for (int p = 0; p < 6; p++) begin
              logic [63:0] e;
              logic legal_upd, ill;
              form = 2'(f); upd = 1'(u);
              ra_num = regsel(a); rt_num = regsel(t);
              case (p)
                0: begin ra_val = 64'h1000; rb_val = 64'h20; imm = 16'h0007; end
                1: begin ra_val = '1; rb_val = 64'h1; imm = 16'hFFFF; end
                2: begin ra_val = 64'h7FFF_FFFF_FFFF_FFF0; rb_val = 64'h10; imm = 16'h8003; end
                3: begin ra_val = 64'h1234_5678_9ABC_DEF0; rb_val = 64'hF000_0000_0000_0000; imm = 16'h7FFD; end
                4: begin ra_val = 64'h0; rb_val = 64'hDEAD_BEEF_0000_0000; imm = 16'h000F; end
                default: begin ra_val = 64'hFFFF_FFFF_FFFF_FF00; rb_val = 64'h200; imm = 16'h8000; end
              endcase
              in_valid = 1'b1;
              e = exp_ea(form, upd, ra_num, ra_val, rb_val, imm);
              ill = upd && (ra_num == 0 || ra_num == rt_num);
              legal_upd = upd && !ill;
              @(posedge clk);
              @(negedge clk);
              chk("R2 out_valid", 64'(out_valid), 1);
              case (f)
                0: chk(u ? "R4 R5 R9 ea D" : "R3 R5 R9 ea D", ea, e);
                1: chk(u ? "R4 R6 R9 ea DS" : "R3 R6 R9 ea DS", ea, e);
                2: chk(u ? "R4 R7 R9 ea DQ" : "R3 R7 R9 ea DQ", ea, e);
                default: chk(u ? "R4 R8 R9 ea X" : "R3 R8 R9 ea X", ea, e);
              endcase
              if (!u) begin
                chk("R12 wb_en", 64'(wb_en), 0);
                chk("R12 bad_form", 64'(bad_form), 0);
              end else if (legal_upd) begin
                chk("R10 wb_en", 64'(wb_en), 1);
                chk("R10 wb_val", wb_val, e);
                chk("R10 bad_form", 64'(bad_form), 0);
              end else begin
                chk("R11 bad_form", 64'(bad_form), 1);
                chk("R11 wb_en", 64'(wb_en), 0);
              end
              if (p == 5) begin
                in_valid = 1'b0;
                upd = 1'b1; ra_num = 5'd0;
                @(posedge clk);
                @(negedge clk);
                chk("R2 idle out_valid", 64'(out_valid), 0);
                chk("R2 idle wb_en", 64'(wb_en), 0);
                chk("R2 idle bad_form", 64'(bad_form), 0);
              end
            end
    in_valid = 1'b0;
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule